// File: doc/BRIEF.md
# Recursive Intra-Row Column Address Generator

This block produces the permuted column index for each row of a prime-sized rectangular interleaver, and it does so without a divider. Every modulo reduction is a bounded add followed by at most one compare and subtract. One shared reduction unit serves three purposes: it reduces each row's prime to a per-row increment, it fills the base-sequence RAM, and it advances the running addresses in run mode.

After a start strobe the block latches the prime `p`, a primitive root `v`, the row count and the per-row primes. It then moves through its named states:

- **ST_IDLE**: waits for `start`. On `start` it latches the inputs, writes S(0)=1 and clears the running addresses. Transition *launch* leads to ST_QRED.
- **ST_QRED**: reduces each row's prime modulo p-1 by repeated subtraction, one subtraction per cycle. Transition *increments_ready*, taken after the last row, leads to ST_SFILL.
- **ST_SFILL**: fills S(1..p-2) by shift-and-add, spending two cycles per bit of `v`. Transition *table_full* leads to ST_RUN.
- **ST_RUN**: visits rows round-robin, one per cycle, through a circular pointer over the per-row state. Transition *last_column* leads to ST_DONE.
- **ST_DONE**: raises the completion strobe. Transition *retire* leads back to ST_IDLE.

Top module: `iam_addr_gen`

## Requirements
- R1: After reset, `col_valid` and `run_done` are low until a run is started.
- R2: For each row i, the increment used is q(i) mod (p-1). Here q(i) is taken from `q_vals[i*10 +: 10]`. A q(i) that is a multiple of p-1 gives an increment of 0, so that row repeats S(0)=1.
- R3: The base sequence is S(0)=1 and S(j)=(v*S(j-1)) mod p for j=1..p-2.
- R4: The running address of every row starts at 0 and advances by its increment modulo p-1 on each visit. The output for row i at column step j is therefore S((j*Qmod(i)) mod (p-1)).
- R5: Outputs come column step outer and row inner. `row_out` runs 0..R-1 and `pos_out` gives the column step. There is one valid output per cycle, with no gap from the first to the last.
- R6: Exactly R*(p-1) valid outputs are produced per run. `run_done` is high for a single cycle, namely the cycle right after the last valid output.
- R7: A `start` pulse, or changed parameter inputs, while a run is in progress have no effect on that run's outputs.
- R8: A start after completion runs again with the newly presented parameters, and the running addresses begin again at 0.
- R9: Every valid `col_idx` lies in 1..p-1. Legal inputs are a prime p with 5 ≤ p < 512, v in 1..p-1, and a row count from 1 to 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when idle |
| prime_p | input | 9 | Prime p |
| root_v | input | 9 | Primitive root of p |
| num_rows | input | 5 | Row count R |
| q_vals | input | 200 | Per-row primes, 10 bits each, row i at bit i*10 |
| col_idx | output | 9 | Permuted column index |
| row_out | output | 5 | Row of the current index |
| pos_out | output | 9 | Column step of the current index |
| col_valid | output | 1 | Output index is valid |
| run_done | output | 1 | One-cycle completion strobe |

## Verification
The setup time before the first output depends on the q values and on p, so the bench does not predict it. It waits for the first valid output, sampling on falling edges. From that cycle on, a valid output is due on every falling edge until R*(p-1) of them have been seen. The bench requires `run_done` exactly one falling edge after the last valid output, and low again one edge later. Each output is compared with S((j*Qmod(i)) mod (p-1)), which the bench computes by plain multiplication and `%`.

// File: rtl/iam_pkg.sv
package iam_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QRED,
        ST_SFILL,
        ST_RUN,
        ST_DONE
    } gen_state_e;
endpackage

// File: rtl/iam_modadd.sv
module iam_modadd #(
    parameter int W = 11
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] modv,
    output logic [W-1:0] res,
    output logic         wrapped
);
    logic [W:0] sum;
    logic [W:0] diff;

    always_comb begin
        sum     = {1'b0, opa} + {1'b0, opb};
        diff    = sum - {1'b0, modv};
        wrapped = (sum >= {1'b0, modv});
        res     = wrapped ? diff[W-1:0] : sum[W-1:0];
    end
endmodule

// File: rtl/iam_seq_ram.sv
module iam_seq_ram #(
    parameter int AW = 9,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
        rd <= mem[ra];
    end
endmodule

// File: rtl/iam_row_ring.sv
module iam_row_ring #(
    parameter int RMAX = 20,
    parameter int RW   = 5,
    parameter int AW   = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          q_we,
    input  logic [RW-1:0] q_wa,
    input  logic [AW-1:0] q_wd,
    input  logic          a_we,
    input  logic [RW-1:0] idx,
    input  logic [AW-1:0] a_wd,
    output logic [AW-1:0] addr_rd,
    output logic [AW-1:0] qm_rd
);
    logic [AW-1:0] addr_q [RMAX];
    logic [AW-1:0] qm_q   [RMAX];

    genvar g;
    generate
        for (g = 0; g < RMAX; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_q[g] <= '0;
                    qm_q[g]   <= '0;
                end else begin
                    if (clr) begin
                        addr_q[g] <= '0;
                    end else if (a_we && idx == RW'(g)) begin
                        addr_q[g] <= a_wd;
                    end
                    if (q_we && q_wa == RW'(g)) begin
                        qm_q[g] <= q_wd;
                    end
                end
            end
        end
    endgenerate

    assign addr_rd = addr_q[idx];
    assign qm_rd   = qm_q[idx];

    // R8: running addresses restart at zero after a launch
    assert_addr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr_rd == '0));

    // R2: increments are never written while addresses advance
    assert_no_dual_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_we && a_we));
endmodule

// File: rtl/iam_addr_gen.sv
module iam_addr_gen #(
    parameter int PW   = 9,
    parameter int QW   = 10,
    parameter int RMAX = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PW-1:0]       prime_p,
    input  logic [PW-1:0]       root_v,
    input  logic [4:0]          num_rows,
    input  logic [RMAX*QW-1:0]  q_vals,
    output logic [PW-1:0]       col_idx,
    output logic [4:0]          row_out,
    output logic [PW-1:0]       pos_out,
    output logic                col_valid,
    output logic                run_done
);
    import iam_pkg::*;

    localparam int RW = 5;
    localparam int DW = ((PW > QW) ? PW : QW) + 1;
    localparam int KW = $clog2(PW);

    gen_state_e st, st_nx;

    logic [PW-1:0]       p_r, v_r, pm1;
    logic [RW-1:0]       nrows_r, row_i, rr;
    logic [RMAX*QW-1:0]  q_r;
    logic [DW-1:0]       qacc;
    logic [PW-1:0]       sj, sacc, sprev, cj, snext;
    logic [KW-1:0]       bitk;
    logic                ph;

    logic [DW-1:0]       md_a, md_b, md_m, md_r;
    logic                md_wrap;

    logic                launch;
    logic                ram_we;
    logic [PW-1:0]       ram_wa, ram_wd;
    logic                ring_qwe, ring_awe;
    logic [RW-1:0]       ring_idx;
    logic [PW-1:0]       ring_addr, ring_qm;

    assign pm1    = p_r - PW'(1);
    assign launch = (st == ST_IDLE) && start;

    // shared reduction unit
    always_comb begin
        md_a = '0;
        md_b = '0;
        md_m = '0;
        unique case (st)
            ST_QRED: begin
                md_a = qacc;
                md_b = '0;
                md_m = DW'(pm1);
            end
            ST_SFILL: begin
                md_a = DW'(sacc);
                md_b = ph ? DW'(sprev) : DW'(sacc);
                md_m = DW'(p_r);
            end
            ST_RUN: begin
                md_a = DW'(ring_addr);
                md_b = DW'(ring_qm);
                md_m = DW'(pm1);
            end
            default: begin
                md_a = '0;
            end
        endcase
    end

    iam_modadd #(.W(DW)) u_mod (
        .opa     (md_a),
        .opb     (md_b),
        .modv    (md_m),
        .res     (md_r),
        .wrapped (md_wrap)
    );

    assign snext = v_r[bitk] ? md_r[PW-1:0] : sacc;

    // base-sequence RAM
    assign ram_we = launch || ((st == ST_SFILL) && ph && (bitk == '0));
    assign ram_wa = launch ? '0 : sj;
    assign ram_wd = launch ? PW'(1) : snext;

    iam_seq_ram #(.AW(PW), .DW(PW)) u_sram (
        .clk (clk),
        .we  (ram_we),
        .wa  (ram_wa),
        .wd  (ram_wd),
        .ra  (ring_addr),
        .rd  (col_idx)
    );

    // per-row state, visited through a circular pointer
    assign ring_qwe = (st == ST_QRED) && !md_wrap;
    assign ring_awe = (st == ST_RUN);
    assign ring_idx = (st == ST_RUN) ? rr : row_i;

    iam_row_ring #(.RMAX(RMAX), .RW(RW), .AW(PW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (launch),
        .q_we    (ring_qwe),
        .q_wa    (row_i),
        .q_wd    (qacc[PW-1:0]),
        .a_we    (ring_awe),
        .idx     (ring_idx),
        .a_wd    (md_r[PW-1:0]),
        .addr_rd (ring_addr),
        .qm_rd   (ring_qm)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = ST_QRED;                              // launch
            ST_QRED:  if (!md_wrap && row_i == nrows_r - RW'(1))
                          st_nx = ST_SFILL;                                   // increments_ready
            ST_SFILL: if (ph && bitk == '0 && sj == p_r - PW'(2))
                          st_nx = ST_RUN;                                     // table_full
            ST_RUN:   if (rr == nrows_r - RW'(1) && cj == p_r - PW'(2))
                          st_nx = ST_DONE;                                    // last_column
            ST_DONE:  st_nx = ST_IDLE;                                        // retire
            default:  st_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_r     <= '0;
            v_r     <= '0;
            nrows_r <= '0;
            q_r     <= '0;
            qacc    <= '0;
            row_i   <= '0;
            sj      <= '0;
            sacc    <= '0;
            sprev   <= '0;
            bitk    <= '0;
            ph      <= 1'b0;
            rr      <= '0;
            cj      <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        p_r     <= prime_p;
                        v_r     <= root_v;
                        nrows_r <= num_rows;
                        q_r     <= q_vals;
                        qacc    <= DW'(q_vals[QW-1:0]);
                        row_i   <= '0;
                        sj      <= PW'(1);
                        sacc    <= '0;
                        sprev   <= PW'(1);
                        bitk    <= KW'(PW - 1);
                        ph      <= 1'b0;
                        rr      <= '0;
                        cj      <= '0;
                    end
                end
                ST_QRED: begin
                    if (md_wrap) begin
                        qacc <= md_r;
                    end else if (row_i != nrows_r - RW'(1)) begin
                        row_i <= row_i + RW'(1);
                        qacc  <= DW'(q_r[(int'(row_i) + 1) * QW +: QW]);
                    end
                end
                ST_SFILL: begin
                    if (!ph) begin
                        sacc <= md_r[PW-1:0];
                        ph   <= 1'b1;
                    end else begin
                        ph <= 1'b0;
                        if (bitk == '0) begin
                            sprev <= snext;
                            sacc  <= '0;
                            bitk  <= KW'(PW - 1);
                            sj    <= sj + PW'(1);
                        end else begin
                            sacc <= snext;
                            bitk <= bitk - KW'(1);
                        end
                    end
                end
                ST_RUN: begin
                    if (rr == nrows_r - RW'(1)) begin
                        rr <= '0;
                        cj <= cj + PW'(1);
                    end else begin
                        rr <= rr + RW'(1);
                    end
                end
                ST_DONE: begin
                    rr <= '0;
                end
                default: begin
                    rr <= '0;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_valid <= 1'b0;
            run_done  <= 1'b0;
            row_out   <= '0;
            pos_out   <= '0;
        end else begin
            col_valid <= (st == ST_RUN);
            run_done  <= (st == ST_DONE);
            row_out   <= rr;
            pos_out   <= cj;
        end
    end

    // R9: indices stay inside the nonzero residues of p
    assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> (col_idx != '0 && col_idx < p_r));

    // R4: running address read from the ring is always reduced
    assert_addr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (ring_addr < pm1));

    // R6: completion is a single-cycle strobe
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !run_done);

    // R6: completion directly follows the last valid output
    assert_done_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> ($past(col_valid) && !col_valid));

    // R5: rows advance by one between consecutive outputs
    assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && row_out != '0) |->
            (row_out == $past(row_out) + 5'd1));
endmodule

// File: tb/iam_addr_gen_test.sv
module iam_addr_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW   = 9;
    localparam int QW   = 10;
    localparam int RMAX = 20;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                start;
    logic [PW-1:0]       prime_p, root_v;
    logic [4:0]          num_rows;
    logic [RMAX*QW-1:0]  q_vals;
    logic [PW-1:0]       col_idx, pos_out;
    logic [4:0]          row_out;
    logic                col_valid, run_done;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iam_addr_gen #(.PW(PW), .QW(QW), .RMAX(RMAX)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .prime_p   (prime_p),
        .root_v    (root_v),
        .num_rows  (num_rows),
        .q_vals    (q_vals),
        .col_idx   (col_idx),
        .row_out   (row_out),
        .pos_out   (pos_out),
        .col_valid (col_valid),
        .run_done  (run_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // q(i) pattern; row 0 may be forced to a multiple of p-1 (R2 corner)
    function automatic int qgen(input int i, input int seed);
        return (37 * i * i + seed * i + 5) % 1024;
    endfunction

    task automatic run_cfg(input int p, input int v, input int nr, input int seed,
                           input bit zero_row0, input bit poke);
        int sx[512];
        int qm[RMAX];
        int total, k, wd;
        bit seen_done, poked;
        sx[0] = 1;
        for (int j = 1; j < p - 1; j++) sx[j] = (v * sx[j-1]) % p;
        @(negedge clk);
        prime_p  = PW'(p);
        root_v   = PW'(v);
        num_rows = 5'(nr);
        for (int i = 0; i < RMAX; i++) begin
            int qv;
            qv = qgen(i, seed);
            if (zero_row0 && i == 0) qv = 2 * (p - 1);
            q_vals[i*QW +: QW] = QW'(qv);
            qm[i] = qv % (p - 1);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        total = nr * (p - 1);
        k = 0;
        wd = 0;
        seen_done = 1'b0;
        poked = 1'b0;
        while (!seen_done && wd < 30000) begin
            @(negedge clk);
            wd++;
            if (start) start = 1'b0;
            if (col_valid) begin
                int er, ej;
                er = k % nr;
                ej = k / nr;
                chk(int'(row_out) == er, "R5 row", int'(row_out), er);
                chk(int'(pos_out) == ej, "R5 pos", int'(pos_out), ej);
                chk(int'(col_idx) == sx[(ej * qm[er]) % (p - 1)],
                    "R4 col", int'(col_idx), sx[(ej * qm[er]) % (p - 1)]);
                k++;
                if (poke && !poked && k == 15) begin
                    // R7: disturb inputs mid-run
                    poked = 1'b1;
                    start = 1'b1;
                    prime_p = 9'd7;
                    num_rows = 5'd3;
                end
            end else if (run_done) begin
                seen_done = 1'b1;
                chk(k == total, "R6 count", k, total);
            end else if (k > 0) begin
                chk(1'b0, "R5 gap", k, total);
            end
        end
        if (!seen_done) chk(1'b0, "watchdog", wd, 30000);
        @(negedge clk);
        chk(!run_done, "R6 pulse", int'(run_done), 0);
        chk(!col_valid, "R6 idle", int'(col_valid), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        prime_p = '0;
        root_v = '0;
        num_rows = '0;
        q_vals = '0;
        repeat (3) @(negedge clk);
        chk(!col_valid, "R1 valid", int'(col_valid), 0);
        chk(!run_done, "R1 done", int'(run_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!col_valid && !run_done, "R1 idle", int'(col_valid), 0);
        // R3, R4: small prime, five rows, zero increment row (R2)
        run_cfg(7, 3, 5, 11, 1'b1, 1'b0);
        // R7: mid-run start and input changes ignored
        run_cfg(11, 2, 10, 23, 1'b0, 1'b1);
        // R8: rerun with new parameters, full row count
        run_cfg(13, 2, 20, 7, 1'b0, 1'b0);
        // R2, R9: larger prime, single row
        run_cfg(31, 3, 1, 5, 1'b0, 1'b0);
        run_cfg(5, 2, 20, 3, 1'b1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule